// File: doc/BRIEF.md
# Versioned LUT truth-table permuter

This block rewrites the 16-entry truth table of a 4-input look-up element so that the element computes the same function after a chosen set of its inputs starts arriving inverted. A 4-bit version code picks the inverted inputs. The block also holds the table of an upstream element that feeds one chosen input. When that input's version bit is set, it stores the upstream table with every bit complemented. The upstream output then really is inverted, and the pair as a whole keeps its function.

A load pulse captures the tables and the version code. A stepping engine then handles one input per clock, from A up to D, and skips inputs whose version bit is clear. For each input it exchanges neighbouring fragments of the table. When the work is finished, a done flag is raised and held until the next accepted load. Two read ports give single table bits at a 4-bit address. One reads the permuted table and the other reads the stored upstream table, so the equivalence of the pair can be tested from outside.

Top module: `lut_ver_permuter`

## Requirements
- R1: While reset is applied and after it is released, with no load yet given, busy_o and done_o are 0 and tbl_o and up_tbl_o are all zero.
- R2: After done_o rises, tbl_o bit (i XOR v) equals source bit i for every index i and every version code v from 0x0 to 0xF. Version bit 0 is input A (address bit 0), bit 1 is B, bit 2 is C and bit 3 is D.
- R3: A version with only bit X set splits the table into fragments of 2^X bits. Each even-numbered fragment (counting from 0) exchanges place with the fragment just above it.
- R4: Source table 0xABBA under version 0xB gives 0xD55D.
- R5: Version 0x0 leaves the table unchanged, and done_o is high at the first sample after the capturing edge.
- R6: The engine performs one single-input step per clock edge. done_o first reads high popcount(v) edges after the capturing edge, and busy_o is high while steps remain.
- R7: Applying version v1 and then version v2 to the result gives the same table as applying v1 XOR v2 in one pass. In particular 0x1 then 0x8 equals 0x8 then 0x1.
- R8: up_tbl_o equals the bitwise complement of the loaded upstream table when version bit UP_SEL (default 3, input D) is set, and equals the loaded table otherwise.
- R9: A load pulse given while busy_o is high is ignored. The result of the running job is unchanged.
- R10: ev_bit_o returns tbl_o[ev_addr_i] and up_bit_o returns up_tbl_o[up_addr_i]. Feed input D from up_bit_o and the other inputs from the address bits XOR their version bits. The result then equals the original table addressed by the original upstream output and the original address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Capture tables and version and start a job (taken only when not busy) |
| tbl_i | input | 16 | Source truth table of the permuted element |
| up_tbl_i | input | 16 | Truth table of the upstream feeding element |
| ver_i | input | 4 | Version code, one inverted-input flag per bit |
| busy_o | output | 1 | Steps still pending |
| done_o | output | 1 | Result ready, held until the next accepted load |
| tbl_o | output | 16 | Permuted truth table |
| up_tbl_o | output | 16 | Stored upstream table, complemented when selected |
| ev_addr_i | input | 4 | Read address into the permuted table |
| ev_bit_o | output | 1 | Permuted table bit at ev_addr_i |
| up_addr_i | input | 4 | Read address into the upstream table |
| up_bit_o | output | 1 | Upstream table bit at up_addr_i |

## Verification
The following are checked on every cycle:
- Each stepping cycle removes exactly one pending version bit.
- A job never stays busy for more than four cycles.
- Once done, the stepped table matches the index-XOR reference.
- The upstream table carries the polarity the version calls for.

Only the bench scenarios can show the rest:
- The exact 0xABBA to 0xD55D vector.
- The fragment layout of each single-input swap.
- The order independence of successive versions.
- That a load given during a running job is dropped.
- That the evaluated pair, with its inputs inverted, gives the same outputs as the original pair.

// File: rtl/lutperm_pkg.sv
package lutperm_pkg;
  localparam int unsigned N_IN  = 4;
  localparam int unsigned TBL_W = 1 << N_IN;
  localparam int unsigned CNT_W = $clog2(N_IN + 1) + 1;

  typedef logic [TBL_W-1:0] tbl_t;
  typedef logic [N_IN-1:0]  ver_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_DONE = 2'd2
  } eng_st_e;

  // Reference mapping: entry i lands at index i XOR v.
  function automatic tbl_t xor_permute(input tbl_t src, input ver_t v);
    tbl_t r;
    r = '0;
    for (int i = 0; i < int'(TBL_W); i++) begin
      r[i ^ int'(v)] = src[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/lutperm_rst_sync.sv
module lutperm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/lutperm_swap_stage.sv
module lutperm_swap_stage
  import lutperm_pkg::*;
#(
  parameter int unsigned LVL = 0
) (
  input  tbl_t tbl_i,
  output tbl_t tbl_o
);
  localparam int FRAG  = 1 << LVL;
  localparam int PAIRS = int'(TBL_W) / (2 * FRAG);

  // Exchange each even fragment with its upper neighbour.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign tbl_o[(2*p)*FRAG   +: FRAG] = tbl_i[(2*p+1)*FRAG +: FRAG];
    assign tbl_o[(2*p+1)*FRAG +: FRAG] = tbl_i[(2*p)*FRAG   +: FRAG];
  end
endmodule

// File: rtl/lutperm_step_engine.sv
module lutperm_step_engine
  import lutperm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  tbl_t tbl_i,
  input  ver_t ver_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o,
  output tbl_t tbl_o
);
  eng_st_e st_q, st_d;
  tbl_t    tbl_q, tbl_d, tbl_step;
  ver_t    pend_q, pend_d, pick;
  logic    reg_en;
  tbl_t    swapped [N_IN];

  for (genvar k = 0; k < int'(N_IN); k++) begin : g_stage
    lutperm_swap_stage #(.LVL(k)) u_swap (
      .tbl_i (tbl_q),
      .tbl_o (swapped[k])
    );
  end

  // Lowest pending input goes first (A before D).
  assign pick = pend_q & (~pend_q + ver_t'(1));

  always_comb begin
    tbl_step = tbl_q;
    for (int k = 0; k < int'(N_IN); k++) begin
      if (pick[k]) tbl_step = swapped[k];
    end
  end

  assign accept_o = load_i && (st_q != ST_STEP);

  always_comb begin
    st_d   = st_q;
    tbl_d  = tbl_q;
    pend_d = pend_q;
    reg_en = 1'b0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (load_i) begin
          reg_en = 1'b1;
          tbl_d  = tbl_i;
          pend_d = ver_i;
          st_d   = (ver_i == '0) ? ST_DONE : ST_STEP;
        end
      end
      ST_STEP: begin
        reg_en = 1'b1;
        tbl_d  = tbl_step;
        pend_d = pend_q & ~pick;
        st_d   = (pend_d == '0) ? ST_DONE : ST_STEP;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tbl_q  <= '0;
      pend_q <= '0;
    end else begin
      st_q <= st_d;
      if (reg_en) begin
        tbl_q  <= tbl_d;
        pend_q <= pend_d;
      end
    end
  end

  assign busy_o = (st_q == ST_STEP);
  assign done_o = (st_q == ST_DONE);
  assign tbl_o  = tbl_q;

  // Checker state: captured job and length of the current run of steps.
  tbl_t             src_sh;
  ver_t             ver_sh;
  logic [CNT_W-1:0] step_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sh   <= '0;
      ver_sh   <= '0;
      step_cnt <= '0;
    end else begin
      if (accept_o) begin
        src_sh <= tbl_i;
        ver_sh <= ver_i;
      end
      step_cnt <= (st_q == ST_STEP) ? step_cnt + 1'b1 : '0;
    end
  end

  a_r2_stepped_matches_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |-> (tbl_q == xor_permute(src_sh, ver_sh)));

  a_r6_one_input_per_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STEP) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  a_r6_step_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STEP) |-> (step_cnt < CNT_W'(N_IN)));

  a_r9_busy_load_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STEP && load_i) |=> (st_q != ST_IDLE) &&
      ($countones(pend_q) < $countones($past(pend_q))));
endmodule

// File: rtl/lutperm_up_store.sv
module lutperm_up_store
  import lutperm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_i,
  input  logic inv_i,
  input  tbl_t tbl_i,
  output tbl_t tbl_o
);
  tbl_t up_q, up_d;

  assign up_d = inv_i ? ~tbl_i : tbl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
    end else if (cap_i) begin
      up_q <= up_d;
    end
  end

  assign tbl_o = up_q;
endmodule

// File: rtl/lutperm_rd_port.sv
module lutperm_rd_port
  import lutperm_pkg::*;
(
  input  tbl_t tbl_i,
  input  ver_t addr_i,
  output logic bit_o
);
  assign bit_o = tbl_i[addr_i];
endmodule

// File: rtl/lut_ver_permuter.sv
module lut_ver_permuter
  import lutperm_pkg::*;
#(
  parameter int unsigned UP_SEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TBL_W-1:0] tbl_i,
  input  logic [TBL_W-1:0] up_tbl_i,
  input  logic [N_IN-1:0]  ver_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [TBL_W-1:0] tbl_o,
  output logic [TBL_W-1:0] up_tbl_o,
  input  logic [N_IN-1:0]  ev_addr_i,
  output logic             ev_bit_o,
  input  logic [N_IN-1:0]  up_addr_i,
  output logic             up_bit_o
);
  logic rst_sync_n;
  logic accept_w;
  tbl_t up_w;

  lutperm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lutperm_step_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load_i),
    .tbl_i    (tbl_i),
    .ver_i    (ver_i),
    .accept_o (accept_w),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .tbl_o    (tbl_o)
  );

  lutperm_up_store u_up (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cap_i (accept_w),
    .inv_i (ver_i[UP_SEL]),
    .tbl_i (up_tbl_i),
    .tbl_o (up_w)
  );

  assign up_tbl_o = up_w;

  lutperm_rd_port u_ev_rd (
    .tbl_i  (tbl_o),
    .addr_i (ev_addr_i),
    .bit_o  (ev_bit_o)
  );

  lutperm_rd_port u_up_rd (
    .tbl_i  (up_w),
    .addr_i (up_addr_i),
    .bit_o  (up_bit_o)
  );

  // Checker state for the upstream polarity rule.
  tbl_t up_sh;
  logic inv_sh;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      up_sh  <= '0;
      inv_sh <= 1'b0;
    end else if (load_i && !busy_o) begin
      up_sh  <= up_tbl_i;
      inv_sh <= ver_i[UP_SEL];
    end
  end

  a_r8_upstream_polarity: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (up_tbl_o == (inv_sh ? ~up_sh : up_sh)));
endmodule

// File: tb/lut_ver_permuter_tb_top.sv
module lut_ver_permuter_tb_top;
  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [15:0] tbl_i, up_tbl_i;
  logic [3:0]  ver_i;
  logic        busy_o, done_o;
  logic [15:0] tbl_o, up_tbl_o;
  logic [3:0]  ev_addr_i, up_addr_i;
  logic        ev_bit_o, up_bit_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] exp_tbl_q [$];
  logic [15:0] exp_up_q  [$];
  string       req_q     [$];

  lut_ver_permuter dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .tbl_i     (tbl_i),
    .up_tbl_i  (up_tbl_i),
    .ver_i     (ver_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .tbl_o     (tbl_o),
    .up_tbl_o  (up_tbl_o),
    .ev_addr_i (ev_addr_i),
    .ev_bit_o  (ev_bit_o),
    .up_addr_i (up_addr_i),
    .up_bit_o  (up_bit_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] idx_xor(input logic [15:0] s, input logic [3:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i ^ int'(v)] = s[i];
    return r;
  endfunction

  function automatic logic [15:0] frag_swap(input logic [15:0] s, input int x);
    logic [15:0] r;
    int f;
    f = 1 << x;
    for (int i = 0; i < 16; i++) begin
      if (((i / f) % 2) == 0) r[i] = s[i + f];
      else                    r[i] = s[i - f];
    end
    return r;
  endfunction

  function automatic int popcnt(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  // Monitor: pops the scoreboard when a result is ready.
  always @(negedge clk) begin
    if (rst_n && done_o && exp_tbl_q.size() > 0) begin
      logic [15:0] et, eu;
      string rq;
      et = exp_tbl_q.pop_front();
      eu = exp_up_q.pop_front();
      rq = req_q.pop_front();
      chk(tbl_o == et, rq, 32'(tbl_o), 32'(et));
      chk(up_tbl_o == eu, "R8 upstream polarity", 32'(up_tbl_o), 32'(eu));
    end
  end

  task automatic run_load(input logic [15:0] t, input logic [15:0] u, input logic [3:0] v,
                          input logic [15:0] exp_t, input string req, output logic [15:0] res);
    int cnt;
    @(negedge clk);
    load_i = 1'b1; tbl_i = t; up_tbl_i = u; ver_i = v;
    @(negedge clk);
    load_i = 1'b0;
    exp_tbl_q.push_back(exp_t);
    exp_up_q.push_back(v[3] ? ~u : u);
    req_q.push_back(req);
    cnt = 0;
    while (!done_o && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == popcnt(v), "R6 latency", 32'(cnt), 32'(popcnt(v)));
    res = tbl_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r1, r2, r3, t;
    rst_n = 1'b0; load_i = 1'b0; tbl_i = '0; up_tbl_i = '0; ver_i = '0;
    ev_addr_i = '0; up_addr_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy_o && !done_o && tbl_o == 0 && up_tbl_o == 0, "R1 in reset",
        {14'd0, busy_o, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && tbl_o == 0 && up_tbl_o == 0, "R1 after release",
        {14'd0, busy_o, done_o}, 32'd0);

    // R4 known vector
    run_load(16'hABBA, 16'h1234, 4'hB, 16'hD55D, "R4 ABBA under B", r1);

    // R5 identity version
    run_load(16'h5AC3, 16'h0F0F, 4'h0, 16'h5AC3, "R5 version zero", r1);

    // R3 single-input fragment swaps
    for (int k = 0; k < 4; k++) begin
      run_load(16'h8E21, 16'hC3A5, 4'(1 << k), frag_swap(16'h8E21, k), "R3 single input", r1);
    end

    // R2 all versions on random tables
    for (int v = 0; v < 16; v++) begin
      t = 16'($urandom);
      run_load(t, 16'($urandom), 4'(v), idx_xor(t, 4'(v)), "R2 xor map", r1);
    end

    // R7 order independence
    t = 16'h3C96;
    run_load(t,  16'h0, 4'h1, idx_xor(t, 4'h1), "R7 step A", r1);
    run_load(r1, 16'h0, 4'h8, idx_xor(t, 4'h9), "R7 A then D", r2);
    run_load(t,  16'h0, 4'h8, idx_xor(t, 4'h8), "R7 step D", r1);
    run_load(r1, 16'h0, 4'h1, idx_xor(t, 4'h9), "R7 D then A", r3);
    chk(r2 == r3, "R7 order", 32'(r3), 32'(r2));

    // R9 load while busy is dropped
    @(negedge clk);
    load_i = 1'b1; tbl_i = 16'hF00D; up_tbl_i = 16'h1111; ver_i = 4'hF;
    @(negedge clk);
    chk(busy_o, "R9 busy seen", {31'd0, busy_o}, 32'd1);
    tbl_i = 16'h0BAD; up_tbl_i = 16'h2222; ver_i = 4'h0;
    @(negedge clk);
    load_i = 1'b0;
    exp_tbl_q.push_back(idx_xor(16'hF00D, 4'hF));
    exp_up_q.push_back(~16'h1111);
    req_q.push_back("R9 busy load ignored");
    repeat (6) @(negedge clk);
    chk(tbl_o == idx_xor(16'hF00D, 4'hF), "R9 result kept", 32'(tbl_o),
        32'(idx_xor(16'hF00D, 4'hF)));

    // R10 pair equivalence through the read ports
    for (int pass = 0; pass < 2; pass++) begin
      logic [15:0] ot, ou;
      logic [3:0]  v;
      ot = (pass == 0) ? 16'hE4B7 : 16'h19D2;
      ou = (pass == 0) ? 16'h6A5C : 16'hB38E;
      v  = (pass == 0) ? 4'hB : 4'h6;
      run_load(ot, ou, v, idx_xor(ot, v), "R10 load", r1);
      for (int ua = 0; ua < 16; ua++) begin
        for (int a = 0; a < 8; a++) begin
          logic orig;
          up_addr_i = 4'(ua);
          #1;
          orig = ot[{ou[ua], 3'(a)}];
          ev_addr_i = {up_bit_o, 3'(a) ^ v[2:0]};
          #1;
          chk(ev_bit_o == orig, "R10 pair equivalence", {31'd0, ev_bit_o}, {31'd0, orig});
        end
      end
    end

    repeat (2) @(negedge clk);
    chk(exp_tbl_q.size() == 0, "R2 scoreboard drained", 32'(exp_tbl_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule